// File: doc/BRIEF.md
# Charge-Pump Lock Indicator

This block produces a lock indication for a charge-pump phase-locked loop. It runs on the crystal clock and watches the two pump drive lines, up and down. For each pump pulse it counts how many crystal cycles the pulse lasts. A pulse that lasts longer than an allowed number of cycles is a wide pulse. A pulse that stays within that number is a narrow pulse.

A reference-period strobe marks the end of each phase-comparison period. The lock output drops straight away when a wide pulse appears. It rises again only after a fixed run of back-to-back reference periods that held nothing but narrow pulses. A period with no pump activity at all also counts toward that run. Losing lock is therefore seen within one period, while regaining lock takes a whole run of periods.

The generation of the pump pulses and the way the flag is read elsewhere on the chip are outside this block.

Top module: `lkd_lock_flag`

## Requirements
- R1: A synchronous active-low reset drives `lock_flag_o` to 0 and empties the run of good periods, so that GOOD_RUN fresh good periods are needed before the flag rises.
- R2: The pump is active in any cycle where `up_i` or `dn_i` is 1. A pulse whose active run lasts at most WIDTH_LIMIT consecutive cycles (default 1) is narrow and does not clear the flag.
- R3: When a pulse's active run reaches WIDTH_LIMIT+1 consecutive cycles, `lock_flag_o` reads 0 after the clock edge that samples that cycle. This happens whether or not a strobe falls in that cycle.
- R4: A period is good when it ends with `ref_strobe_i` = 1 and held no wide pulse. `lock_flag_o` becomes 1 on the strobe edge that ends the GOOD_RUN-th consecutive good period (default 8).
- R5: A wide pulse empties the run of good periods, and the period that contains it does not count. After a wide pulse, GOOD_RUN further good periods are needed.
- R6: A reference period with no pump activity counts as a good period.
- R7: While the flag is 1, further good periods keep it at 1. The run count saturates at GOOD_RUN.
- R8: Without a wide pulse, `lock_flag_o` changes only on a clock edge that samples `ref_strobe_i` = 1.
- R9: Up and down activity join into one active run. An up cycle followed at once by a down cycle forms a two-cycle pulse, which is wide at the default limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock; pulse widths are measured in its cycles |
| rst_ni | input | 1 | Synchronous active-low reset |
| up_i | input | 1 | Pump up drive from the phase detector |
| dn_i | input | 1 | Pump down drive from the phase detector |
| ref_strobe_i | input | 1 | One-cycle marker for the last cycle of a reference period |
| lock_flag_o | output | 1 | 1 while the loop is judged locked |

## Verification
The bench builds the block with its default values: a width limit of one crystal cycle and a run of eight good periods. It drives a reference period of sixteen cycles. With these values the one-cycle versus two-cycle width boundary can be reached directly. So can the exact eighth-period rise after seven good periods, which come either from a fresh reset or right after a wide pulse. The short period keeps dozens of lock and unlock episodes, including pulses that switch from up to down partway through, well inside the run time.

// File: rtl/lkd_pkg.sv
// Shared defaults and types for the lock-indicator block.
// Assumes: the event struct is produced once per crystal cycle by the width meter.
package lkd_pkg;

    localparam int unsigned DEF_WIDTH_LIMIT = 1;
    localparam int unsigned DEF_GOOD_RUN    = 8;

    // Per-cycle pump event seen by the run counter and the flag register.
    typedef struct packed {
        logic active;   // up or down asserted this cycle
        logic wide;     // current active run has exceeded the width limit
    } pulse_evt_t;

endpackage

// File: rtl/lkd_width_meter.sv
// Measures the length of the current pump pulse in crystal cycles.
// It reports, in the same cycle, when the active run exceeds WIDTH_LIMIT.
// Assumes: up and down are synchronous to clk_i, and either one counts as activity.
module lkd_width_meter
    import lkd_pkg::*;
#(
    parameter int unsigned WIDTH_LIMIT = DEF_WIDTH_LIMIT
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       up_i,
    input  logic       dn_i,
    output pulse_evt_t evt_o
);

    logic active;

    assign active       = up_i | dn_i;
    assign evt_o.active = active;

    generate
        if (WIDTH_LIMIT == 0) begin : g_any
            // Zero limit: any active cycle is already too wide.
            assign evt_o.wide = active;
        end else begin : g_count
            localparam int unsigned     CW  = $clog2(WIDTH_LIMIT + 1);
            localparam logic [CW-1:0]   LIM = CW'(WIDTH_LIMIT);

            logic [CW-1:0] run_q;

            // Count earlier consecutive active cycles, saturating at the limit.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    run_q <= '0;
                end else if (!active) begin
                    run_q <= '0;
                end else if (run_q != LIM) begin
                    run_q <= run_q + 1'b1;
                end
            end

            assign evt_o.wide = active && (run_q == LIM);

            // R3
            wide_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(evt_o.wide) && active) |-> evt_o.wide);

            // R2
            wide_needs_history_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                evt_o.wide |-> $past(active));
        end
    endgenerate

endmodule

// File: rtl/lkd_run_counter.sv
// Counts consecutive reference periods that held only narrow pulses.
// It tells the flag register when the current strobe completes the qualifying run.
// Assumes: ref_strobe_i marks the last cycle of each period, and a wide event empties the run at once.
module lkd_run_counter
    import lkd_pkg::*;
#(
    parameter int unsigned GOOD_RUN = DEF_GOOD_RUN
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  pulse_evt_t evt_i,
    input  logic       strobe_i,
    output logic       qualify_o,
    output logic       run_full_o
);

    localparam int unsigned      CNTW = $clog2(GOOD_RUN + 1);
    localparam logic [CNTW-1:0]  FULL = CNTW'(GOOD_RUN);
    localparam logic [CNTW-1:0]  LAST = CNTW'(GOOD_RUN - 1);

    logic            bad_q;
    logic [CNTW-1:0] cnt_q;
    logic            period_good;

    // Remember a wide pulse seen since the previous strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bad_q <= 1'b0;
        end else if (strobe_i) begin
            bad_q <= 1'b0;
        end else if (evt_i.wide) begin
            bad_q <= 1'b1;
        end
    end

    assign period_good = strobe_i && !bad_q && !evt_i.wide;

    // Advance the run on each good period; empty it on any wide pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (evt_i.wide) begin
            cnt_q <= '0;
        end else if (period_good && (cnt_q != FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qualify_o  = period_good && (cnt_q >= LAST);
    assign run_full_o = (cnt_q == FULL);

    // R7
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= FULL);

    // R5
    wide_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i.wide |=> (cnt_q == '0));

    // R4
    count_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnt_q != '0) && (cnt_q != $past(cnt_q))) |-> $past(strobe_i));

    // R6
    idle_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !bad_q && !evt_i.active && (cnt_q != FULL)) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lkd_lock_flag.sv
// Top of the lock indicator: the width meter feeds the period run counter.
// The flag register clears on a wide pulse and sets when a run qualifies.
// Assumes: all inputs are synchronous to the crystal clock clk_i.
module lkd_lock_flag
    import lkd_pkg::*;
#(
    parameter int unsigned WIDTH_LIMIT = DEF_WIDTH_LIMIT,
    parameter int unsigned GOOD_RUN    = DEF_GOOD_RUN
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic up_i,
    input  logic dn_i,
    input  logic ref_strobe_i,
    output logic lock_flag_o
);

    pulse_evt_t evt;
    logic       qualify;
    logic       run_full;
    logic       flag_q;

    lkd_width_meter #(.WIDTH_LIMIT(WIDTH_LIMIT)) meter_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .up_i   (up_i),
        .dn_i   (dn_i),
        .evt_o  (evt)
    );

    lkd_run_counter #(.GOOD_RUN(GOOD_RUN)) runs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (evt),
        .strobe_i   (ref_strobe_i),
        .qualify_o  (qualify),
        .run_full_o (run_full)
    );

    // Hold the lock flag: a wide pulse wins over a qualifying strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (evt.wide) begin
            flag_q <= 1'b0;
        end else if (qualify) begin
            flag_q <= 1'b1;
        end
    end

    assign lock_flag_o = flag_q;

    // R3
    wide_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt.wide |=> !lock_flag_o);

    // R8
    flag_rise_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_flag_o) |-> $past(ref_strobe_i));

    // R4
    rise_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_flag_o) |-> run_full);

endmodule

// File: tb/lkd_lock_flag_tb_top.sv
`timescale 1ns/1ps
module lkd_lock_flag_tb_top;

    localparam int LIMIT = 1;
    localparam int RUN   = 8;
    localparam int P     = 16;
    localparam int NV    = 28;

    // Vector fields: {pulse width[3:0], use down[0], flag expected after strobe[0]}
    localparam logic [5:0] VEC [NV] = '{
        {4'd1,1'b0,1'b0}, {4'd0,1'b0,1'b0}, {4'd1,1'b1,1'b0}, {4'd0,1'b0,1'b0},
        {4'd1,1'b0,1'b0}, {4'd1,1'b1,1'b0}, {4'd0,1'b0,1'b0}, {4'd1,1'b0,1'b1},
        {4'd0,1'b0,1'b1}, {4'd1,1'b1,1'b1}, {4'd2,1'b1,1'b0}, {4'd1,1'b0,1'b0},
        {4'd1,1'b0,1'b0}, {4'd1,1'b0,1'b0}, {4'd1,1'b0,1'b0}, {4'd1,1'b0,1'b0},
        {4'd1,1'b0,1'b0}, {4'd1,1'b0,1'b0}, {4'd3,1'b0,1'b0}, {4'd0,1'b0,1'b0},
        {4'd0,1'b0,1'b0}, {4'd0,1'b0,1'b0}, {4'd0,1'b0,1'b0}, {4'd0,1'b0,1'b0},
        {4'd0,1'b0,1'b0}, {4'd0,1'b0,1'b0}, {4'd1,1'b1,1'b1}, {4'd4,1'b0,1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up = 1'b0;
    logic dn = 1'b0;
    logic strobe = 1'b0;
    logic flag;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    lkd_lock_flag #(.WIDTH_LIMIT(LIMIT), .GOOD_RUN(RUN)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .up_i         (up),
        .dn_i         (dn),
        .ref_strobe_i (strobe),
        .lock_flag_o  (flag)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", what, act, exp);
        end
    endtask

    // One reference period: pulse at its start, strobe in its last cycle.
    task automatic run_period(input int width, input bit use_dn, input logic exp_end, input string what);
        logic pre_val;
        bit   moved = 0;
        pre_val = flag;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            if (k > 0 && flag !== pre_val) moved = 1;
            up     = (k < width) && !use_dn;
            dn     = (k < width) && use_dn;
            strobe = (k == P - 1);
        end
        @(negedge clk);
        check(flag, exp_end, what);
        up = 1'b0; dn = 1'b0; strobe = 1'b0;
        if (width <= LIMIT) begin
            checks++;
            if (moved) begin
                errors++;
                $display("FAIL R8 flag moved before strobe: actual=changed expected=%b", pre_val);
            end
        end
    endtask

    task automatic idle_rest(input int from_k);
        for (int k = from_k; k < P; k++) begin
            @(negedge clk);
            strobe = (k == P - 1);
        end
        @(negedge clk);
        strobe = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(flag, 1'b0, "R1 flag during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(flag, 1'b0, "R1 flag after reset");

        // Table walk: R2 narrow, R4 run, R5 wide reset, R6 idle, R7 hold, R9 down
        for (int i = 0; i < NV; i++) begin
            int    w;
            string tag;
            w = int'(VEC[i][5:2]);
            if (w == 0)          tag = "R6 idle period";
            else if (w > LIMIT)  tag = "R5 wide period";
            else if (VEC[i][1])  tag = "R9 narrow down period";
            else                 tag = "R2 narrow up period";
            run_period(w, VEC[i][1], VEC[i][0], $sformatf("%s vec %0d", tag, i));
        end

        // R3: clear on the second active cycle, mid-period
        for (int i = 0; i < RUN; i++)
            run_period(1, 1'b0, (i == RUN - 1), "R4 relock run");
        @(negedge clk); up = 1'b1;
        @(negedge clk); check(flag, 1'b1, "R2 single active cycle keeps lock");
        @(negedge clk); check(flag, 1'b0, "R3 clear on second active cycle"); up = 1'b0;
        idle_rest(2);
        check(flag, 1'b0, "R5 period with wide pulse stays unlocked");

        // R9: up then down back to back is one two-cycle pulse
        for (int i = 0; i < RUN; i++)
            run_period(0, 1'b0, (i == RUN - 1), "R6 relock by idle periods");
        @(negedge clk); up = 1'b1;
        @(negedge clk); up = 1'b0; dn = 1'b1;
        @(negedge clk); check(flag, 1'b0, "R9 up then down merges into wide"); dn = 1'b0;
        idle_rest(2);

        // R1: reset in lock empties the run
        for (int i = 0; i < RUN; i++)
            run_period(1, 1'b1, (i == RUN - 1), "R4 relock run");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(flag, 1'b0, "R1 reset while locked");
        for (int i = 0; i < RUN; i++)
            run_period(1, 1'b0, (i == RUN - 1), "R1 full run needed after reset");
        run_period(0, 1'b0, 1'b1, "R7 lock holds after run");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule